// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers 64 interrupt sources into two banks of 32 and presents one request line to a processor. Each source input passes through a two-stage synchronizer. Edge-type sources latch a rising edge into an event register while they are enabled. Level-type sources are chosen by a fixed mask parameter for each bank. They never latch: they request for as long as their synchronized input is high and they are enabled.

Software reaches the banks through a small word-addressed register port. Each bank has a block of four words, which hold the latched events, the enable bits, a write-one-to-clear acknowledge, and the live input state. The controller always drives the number of the highest-priority pending source, with a valid flag, so the handler can read the vector directly instead of scanning the registers.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every event bit is 0, `irq_o` is 0 and `vec_valid_o` is 0.
- R2: Bank 0 (sources 0..31) decodes at byte offset 0x20 and bank 1 (sources 32..63) at 0x10. Inside a bank the words are event +0x0, enable +0x4, ack +0x8 and level +0xC. Only offsets whose low two bits are 0 decode. Reading the enable word returns the value last written to it.
- R3: The level word returns the source inputs after two clock edges of synchronization, not latched. An input change before edge k is readable after edge k+1.
- R4: An edge-type event bit (mask bit 0) is set only by a rising edge of its synchronized input while the bit is enabled. The bit is readable, and requests, after the third edge following the input change. It stays set after the input falls.
- R5: Enabling an edge-type source whose input is already high sets no event bit and raises no request.
- R6: Writing 1 to an ack bit clears that event bit. Ack bits written as 0 have no effect. A new edge in the same cycle as its ack leaves the event bit set.
- R7: A level-type source (mask bit 1, default bank 0 mask 0x1ff00000, bank 1 mask 0) requests while its synchronized input is high and it is enabled. It never sets its event bit.
- R8: The pending word of a bank is (event OR (level AND mask)) AND enable. `irq_o` is the OR of all 64 pending bits.
- R9: `vec_o` is the highest-numbered pending source, with bank 1 (32..63) above bank 0. `vec_valid_o` is 1 exactly when something is pending.
- R10: Writes to the event and level words change nothing. The ack word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw source inputs, bit n is source n |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 6 | Highest pending source number |
| vec_valid_o | output | 1 | `vec_o` holds a pending source |

## Verification
A source change is due in the level word two edges after it is driven. It is due in the event word, `irq_o` and `vec_o` one edge later. A register write takes effect at the edge that samples the strobe, and the read data and vector follow combinationally from the state held after that edge. The reference model in the bench delays the inputs through a history queue of the same depth. It is compared with every output on each falling edge. The directed checks sample at the exact falling edge where a change first becomes due, and one edge earlier, so that an extra or missing register stage is caught.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LO_BASE = 'h20,
  parameter logic [ADDR_W-1:0] HI_BASE = 'h10,
  parameter logic [DATA_W-1:0] LVL_MASK_LO = 32'h1ff0_0000,
  parameter logic [DATA_W-1:0] LVL_MASK_HI = 32'h0000_0000,
  localparam int NSRC = 2 * DATA_W,
  localparam int VEC_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  localparam int NBANK = 2;

  typedef enum logic [1:0] {W_EVENT, W_ENABLE, W_ACK, W_LEVEL} word_e;

  logic [NBANK-1:0][DATA_W-1:0] lvl_mask;
  assign lvl_mask = {LVL_MASK_HI, LVL_MASK_LO};

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  logic [NBANK-1:0][DATA_W-1:0] lvl, rise;
  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  word_e            sel;
  logic [NBANK-1:0] hit;
  logic             aligned;
  assign sel     = word_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hit[0]  = aligned && (bus_addr[ADDR_W-1:4] == LO_BASE[ADDR_W-1:4]);
  assign hit[1]  = aligned && (bus_addr[ADDR_W-1:4] == HI_BASE[ADDR_W-1:4]);

  logic [NBANK-1:0][DATA_W-1:0] ev_q, en_q, ack_bits, new_ev, pend;
  logic [NBANK-1:0]             en_we;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      en_we[b]    = bus_we && hit[b] && (sel == W_ENABLE);
      ack_bits[b] = (bus_we && hit[b] && (sel == W_ACK)) ? bus_wdata : '0;
      new_ev[b]   = rise[b] & en_q[b] & ~lvl_mask[b];
      pend[b]     = (ev_q[b] | (lvl[b] & lvl_mask[b])) & en_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      en_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        ev_q[b] <= (ev_q[b] & ~ack_bits[b]) | new_ev[b];
        if (en_we[b]) en_q[b] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit[b]) begin
        case (sel)
          W_EVENT:  bus_rdata = ev_q[b];
          W_ENABLE: bus_rdata = en_q[b];
          W_LEVEL:  bus_rdata = lvl[b];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  logic [NSRC-1:0] pend_all;
  assign pend_all = pend;
  assign irq_o    = |pend_all;

  always_comb begin
    vec_o       = '0;
    vec_valid_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_all[i]) begin
        vec_o       = VEC_W'(i);
        vec_valid_o = 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && ev_q == '0));

  p_event_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(rise & en_q)) == '0));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bits != '0) |=> ((ev_q & $past(ack_bits) & ~$past(new_ev)) == '0));

  p_level_never_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & lvl_mask) == '0);

  p_valid_matches_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o == irq_o);

  p_vector_is_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((pend_all >> vec_o) == NSRC'(1)));
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, vvalid;
  logic [5:0]  vec;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .vec_o(vec),
    .vec_valid_o(vvalid)
  );

  localparam logic [5:0] B0 = 6'h20, B1 = 6'h10;
  localparam logic [5:0] EV = 6'h0, EN = 6'h4, ACK = 6'h8, LV = 6'hC;

  logic [63:0] hist[$];
  logic [31:0] m_en [2];
  logic [31:0] m_ev [2];
  logic [31:0] m_mask [2];
  initial begin
    m_mask[0] = 32'h1ff0_0000;
    m_mask[1] = 32'h0;
  end

  function automatic int bank_of(logic [5:0] a);
    if (a[1:0] != 0) return -1;
    if (a[5:4] == 2'b10) return 0;
    if (a[5:4] == 2'b01) return 1;
    return -1;
  endfunction

  function automatic logic [63:0] m_pend();
    logic [63:0] lv;
    lv = hist[1];
    return {(m_ev[1] | (lv[63:32] & m_mask[1])) & m_en[1],
            (m_ev[0] | (lv[31:0] & m_mask[0])) & m_en[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{64'd0, 64'd0, 64'd0};
      for (int b = 0; b < 2; b++) begin m_en[b] = '0; m_ev[b] = '0; end
    end else begin
      logic [63:0] up;
      int bk;
      up = hist[1] & ~hist[2];
      bk = bank_of(addr);
      for (int b = 0; b < 2; b++) begin
        logic [31:0] ackw;
        ackw = (we && bk == b && addr[3:2] == 2'd2) ? wdata : 32'd0;
        m_ev[b] = (m_ev[b] & ~ackw) | (up[b*32 +: 32] & m_en[b] & ~m_mask[b]);
        if (we && bk == b && addr[3:2] == 2'd1) m_en[b] = wdata;
      end
      hist.push_front(src);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      logic [63:0] p;
      logic [31:0] rd;
      int bk;
      int top;
      p = m_pend();
      top = -1;
      for (int i = 0; i < 64; i++) if (p[i]) top = i;
      chk("R8 irq model", irq, p != 0);
      chk("R9 valid model", vvalid, top >= 0);
      if (top >= 0) chk("R9 vector model", vec, top[5:0]);
      bk = bank_of(addr);
      rd = '0;
      if (bk >= 0) begin
        case (addr[3:2])
          2'd0: rd = m_ev[bk];
          2'd1: rd = m_en[bk];
          2'd3: rd = bk ? hist[1][63:32] : hist[1][31:0];
          default: rd = '0;
        endcase
      end
      chk("R2 read model", rdata, rd);
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    settle(1);
    addr = a; wdata = d; we = 1'b1;
    settle(1);
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    settle(4);
    rst_n = 1'b1;
    live = 1'b1;
    settle(1);
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 valid after reset", vvalid, 0);
    rd_chk(B0 + EN, 0, "R1 bank0 enable");
    rd_chk(B1 + EN, 0, "R1 bank1 enable");

    // R4 edge latch and R3 synchronizer delay
    wr(B0 + EN, 32'h8);
    rd_chk(B0 + EN, 32'h8, "R2 enable readback");
    addr = B0 + LV;
    src[3] = 1'b1;
    settle(1);
    rd_chk(B0 + LV, 0, "R3 level one edge early");
    settle(1);
    rd_chk(B0 + LV, 32'h8, "R3 level after two edges");
    chk("R4 no request yet", irq, 0);
    settle(1);
    chk("R4 request after three edges", irq, 1);
    chk("R4 vector", vec, 3);
    src[3] = 1'b0;
    settle(4);
    rd_chk(B0 + EV, 32'h8, "R4 event held after fall");

    // R6 ack behaviour
    wr(B0 + ACK, 32'h0);
    chk("R6 zero ack no effect", irq, 1);
    wr(B0 + ACK, 32'h8);
    chk("R6 ack clears", irq, 0);
    rd_chk(B0 + ACK, 0, "R10 ack reads zero");

    // R5 enable while high
    src[5] = 1'b1;
    settle(4);
    wr(B0 + EN, 32'h28);
    settle(3);
    chk("R5 no request", irq, 0);
    rd_chk(B0 + EV, 0, "R5 no event");

    // R6 edge in same cycle as ack
    src[3] = 1'b1;
    settle(1);
    wr(B0 + ACK, 32'h8);
    chk("R6 new edge survives ack", irq, 1);
    chk("R6 vector", vec, 3);
    src[3] = 1'b0;
    wr(B0 + ACK, 32'h8);
    chk("R6 cleared afterwards", irq, 0);

    // R7 level source
    wr(B0 + EN, 32'h8040_0028);
    src[22] = 1'b1;
    settle(3);
    chk("R7 level request", irq, 1);
    chk("R7 level vector", vec, 22);
    rd_chk(B0 + EV, 0, "R7 level not latched");
    src[22] = 1'b0;
    settle(3);
    chk("R7 level released", irq, 0);

    // R9 priority across banks
    wr(B1 + EN, 32'h1);
    rd_chk(B1 + EN, 32'h1, "R2 bank1 enable readback");
    src[32] = 1'b1;
    src[31] = 1'b1;
    settle(3);
    chk("R9 bank1 wins", vec, 32);
    wr(B1 + ACK, 32'h1);
    chk("R9 falls to bank0 top", vec, 31);
    wr(B0 + ACK, 32'h8000_0000);
    chk("R9 none pending", vvalid, 0);
    src[3] = 1'b1;
    src[22] = 1'b1;
    settle(3);
    chk("R9 higher bit wins", vec, 22);
    wr(B0 + ACK, 32'h8);
    chk("R8 level keeps request", irq, 1);

    // R10 writes to read-only words
    wr(B0 + EV, 32'hffff_ffff);
    wr(B0 + LV, 32'hffff_ffff);
    wr(B1 + EV, 32'hffff_ffff);
    rd_chk(B0 + EV, 0, "R10 event write ignored");
    rd_chk(B1 + EV, 0, "R10 bank1 event write ignored");
    rd_chk(B0 + LV, 32'h8040_0028, "R10 level write ignored");
    chk("R10 vector unchanged", vec, 22);
    src = '0;
    settle(4);
    chk("R8 idle at end", irq, 0);
    finish_run();
  end
endmodule